// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Slice Bank

This block is a bank of ten programmable output slices driven from one shared AND array, in the manner of a small programmable logic device. Each array column is the true or complement form of one signal. The signals are the external inputs, the level of the device clock pin, and one feedback signal per slice. Each product term is the AND of the literals its fuse row connects. Every slice ORs its own fixed set of product terms.

A two-bit mode word per slice selects one of two paths for that sum. The sum can be captured in a D register on a device-clock rising edge, or it can go straight to the pin. An inverting stage after that choice sets the output polarity. Every slice also has its own output-enable product term. Two further product terms are shared by all slices: a synchronous preset and a clear that does not wait for a device-clock edge.

All fuse and mode bits are loaded through a serial load port. While a load is in progress the outputs are disabled and the registers hold. The whole block runs on one system clock `clk`. The device clock `pld_clk` is an ordinary input that is sampled on that clock, which lets it also feed the array.

Top module: `pld_olmc_bank`

## Requirements
- R1: There are ten slices. Slices 4 and 5 OR ten product terms each; the other eight OR eight each. In the fuse image, slice s owns one output-enable row followed by its sum rows, slices follow in ascending order, and the clear row and then the preset row come last.
- R2: Each fuse row has 2·NSIG columns. Column 2k is the true form of signal k and column 2k+1 is its complement. A 1 connects the literal. A row with no fuse set evaluates false, so unused sum terms contribute nothing.
- R3: When mode bit 1 is 1 (combinational), the pin value is the OR of the slice's terms through the polarity stage, in the same cycle as the input change.
- R4: When mode bit 1 is 0 (registered), the register loads the OR sum at a `clk` edge where `pld_clk` is 1 and was 0 at the previous `clk` edge. The pin shows the register only from that edge on.
- R5: Mode bit 0 set to 1 gives active-high output and 0 gives active-low. The inversion is applied after the register or combinational choice, so a register holding 1 drives 0 on an active-low pin.
- R6: When the preset term is true at a device-clock edge, every register becomes 1.
- R7: When the clear term is true at any `clk` edge, every register becomes 0 without waiting for a device-clock edge. The clear wins over the preset.
- R8: `pin_oe[s]` is slice s's enable term, and all enables are 0 while `cfg_en` is 1.
- R9: The feedback of a registered slice is its register. The feedback of a combinational slice is `pin_in[s]`.
- R10: `rst` clears every register and every fuse and mode bit. Afterwards all slices are registered and active-low, so `pin_out` is all ones, `pin_oe` is zero and `fb_bus` is zero.
- R11: While `cfg_en` is 1, each `clk` edge shifts `cfg_bit` into the image. After CFG_W shifts, the bit presented i-th sits at image index i, and mode bits for slice s are at FUSE_W+2s (polarity) and FUSE_W+2s+1 (path). Registers hold during the load.
- R12: The level of `pld_clk` is array signal N_IN. The inputs are signals 0..N_IN-1, and slice s feedback is signal N_IN+1+s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_en | input | 1 | Serial configuration load active |
| cfg_bit | input | 1 | Configuration data bit |
| in_bus | input | N_IN | Dedicated array inputs |
| pld_clk | input | 1 | Device clock pin level, also an array input |
| pin_in | input | N_SL | Pad levels seen at the slice pins |
| pin_out | output | N_SL | Slice output values |
| pin_oe | output | N_SL | Slice output enables |
| fb_bus | output | N_SL | Feedback signals into the array |

## Verification
Combinational pin values, enables and feedback react in the same cycle as an input change. The bench therefore drives just after a rising `clk` edge and samples on the falling edge that follows. Registered values change only at the first `clk` edge that sees `pld_clk` high after low, and clear-term effects appear at the next `clk` edge. Every check of those results waits exactly one rising edge past the stimulus. A configuration image takes CFG_W edges to load, and the reference model adopts the new image only after the final shift edge.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  typedef struct packed {
    logic comb;    // 1: combinational path, 0: registered
    logic act_hi;  // 1: active-high pin, 0: inverted
  } mc_mode_t;

  function automatic int slice_terms(input int s, input int wide_a, input int wide_b,
                                     input int t_narrow, input int t_wide);
    return (s == wide_a || s == wide_b) ? t_wide : t_narrow;
  endfunction

  // first row (enable row) owned by slice s
  function automatic int row_base(input int s, input int wide_a, input int wide_b,
                                  input int t_narrow, input int t_wide);
    int acc;
    acc = 0;
    for (int j = 0; j < s; j++) acc += 1 + slice_terms(j, wide_a, wide_b, t_narrow, t_wide);
    return acc;
  endfunction

endpackage

// File: rtl/olmc_pterm.sv
module olmc_pterm #(
  parameter int COLS = 38
) (
  input  logic [COLS-1:0] fuse_row,
  input  logic [COLS-1:0] lits,
  output logic            hit
);
  // empty row is false; otherwise AND of connected literals
  assign hit = (|fuse_row) & (&(~fuse_row | lits));
endmodule

// File: rtl/olmc_cfg_chain.sv
module olmc_cfg_chain #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] image
);
  always_ff @(posedge clk) begin
    if (rst)           image <= '0;
    else if (shift_en) image <= {bit_in, image[W-1:1]};
  end
endmodule

// File: rtl/olmc_slice.sv
module olmc_slice
  import olmc_pkg::*;
#(
  parameter int COLS  = 38,
  parameter int TERMS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TERMS*COLS-1:0] sum_fuse,
  input  logic [COLS-1:0]       oe_fuse,
  input  logic [COLS-1:0]       lits,
  input  mc_mode_t              mode,
  input  logic                  clr,
  input  logic                  cap,
  input  logic                  preset,
  input  logic                  hold_off,
  input  logic                  pad_in,
  output logic                  pin_o,
  output logic                  oe_o,
  output logic                  fb_o,
  output logic                  q_o
);
  logic [TERMS-1:0] hits;
  logic             sum, oe_hit, path, q;

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    olmc_pterm #(.COLS(COLS)) term_i (
      .fuse_row(sum_fuse[t*COLS +: COLS]),
      .lits    (lits),
      .hit     (hits[t])
    );
  end

  olmc_pterm #(.COLS(COLS)) oe_term_i (
    .fuse_row(oe_fuse),
    .lits    (lits),
    .hit     (oe_hit)
  );

  assign sum = |hits;

  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (cap)   q <= preset | sum;
  end

  assign path  = mode.comb ? sum : q;
  assign pin_o = mode.act_hi ? path : ~path;
  assign oe_o  = oe_hit & ~hold_off;
  assign fb_o  = mode.comb ? pad_in : q;
  assign q_o   = q;
endmodule

// File: rtl/pld_olmc_bank.sv
module pld_olmc_bank
  import olmc_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int N_SL     = 10,
  parameter int T_NARROW = 8,
  parameter int T_WIDE   = 10,
  parameter int WIDE_A   = 4,
  parameter int WIDE_B   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  input  logic [N_IN-1:0] in_bus,
  input  logic            pld_clk,
  input  logic [N_SL-1:0] pin_in,
  output logic [N_SL-1:0] pin_out,
  output logic [N_SL-1:0] pin_oe,
  output logic [N_SL-1:0] fb_bus
);
  localparam int NSIG   = N_IN + 1 + N_SL;
  localparam int COLS   = 2 * NSIG;
  localparam int ROWS   = row_base(N_SL, WIDE_A, WIDE_B, T_NARROW, T_WIDE) + 2;
  localparam int CLR_RW = ROWS - 2;
  localparam int SET_RW = ROWS - 1;
  localparam int FUSE_W = ROWS * COLS;
  localparam int CFG_W  = FUSE_W + 2 * N_SL;

  logic [CFG_W-1:0] image;
  logic [NSIG-1:0]  sig;
  logic [COLS-1:0]  lits;
  logic             ck_q, pld_edge, ar_hit, sp_hit, clr, cap;
  logic [N_SL-1:0]  q_bus;

  olmc_cfg_chain #(.W(CFG_W)) chain_i (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .bit_in(cfg_bit), .image(image)
  );

  always_ff @(posedge clk) begin
    if (rst) ck_q <= 1'b0;
    else     ck_q <= pld_clk;
  end
  assign pld_edge = pld_clk & ~ck_q;

  assign sig = {fb_bus, pld_clk, in_bus};
  for (genvar k = 0; k < NSIG; k++) begin : g_lit
    assign lits[2*k]   = sig[k];
    assign lits[2*k+1] = ~sig[k];
  end

  olmc_pterm #(.COLS(COLS)) clr_term_i (
    .fuse_row(image[CLR_RW*COLS +: COLS]), .lits(lits), .hit(ar_hit)
  );
  olmc_pterm #(.COLS(COLS)) set_term_i (
    .fuse_row(image[SET_RW*COLS +: COLS]), .lits(lits), .hit(sp_hit)
  );

  assign clr = ar_hit & ~cfg_en;
  assign cap = pld_edge & ~cfg_en;

  for (genvar s = 0; s < N_SL; s++) begin : g_slice
    localparam int TS = slice_terms(s, WIDE_A, WIDE_B, T_NARROW, T_WIDE);
    localparam int RB = row_base(s, WIDE_A, WIDE_B, T_NARROW, T_WIDE);
    olmc_slice #(.COLS(COLS), .TERMS(TS)) slice_i (
      .clk     (clk),
      .rst     (rst),
      .sum_fuse(image[(RB+1)*COLS +: TS*COLS]),
      .oe_fuse (image[RB*COLS +: COLS]),
      .lits    (lits),
      .mode    (mc_mode_t'(image[FUSE_W+2*s +: 2])),
      .clr     (clr),
      .cap     (cap),
      .preset  (sp_hit),
      .hold_off(cfg_en),
      .pad_in  (pin_in[s]),
      .pin_o   (pin_out[s]),
      .oe_o    (pin_oe[s]),
      .fb_o    (fb_bus[s]),
      .q_o     (q_bus[s])
    );
  end
endmodule

// File: rtl/olmc_bank_chk.sv
module olmc_bank_chk #(
  parameter int N_SL = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_en,
  input logic [N_SL-1:0] pin_out,
  input logic [N_SL-1:0] pin_oe,
  input logic [N_SL-1:0] q_bus,
  input logic            ar_hit,
  input logic            sp_hit,
  input logic            pld_edge
);
  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '1 && pin_oe == '0));

  // R8
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> pin_oe == '0);

  // R11
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_en)) |-> q_bus == $past(q_bus));

  // R7
  clear_now_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ar_hit && !cfg_en)) |-> q_bus == '0);

  // R6
  preset_all_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pld_edge && sp_hit && !ar_hit && !cfg_en)) |-> q_bus == '1);
endmodule

bind pld_olmc_bank olmc_bank_chk #(.N_SL(N_SL)) chk_i (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .pin_out(pin_out), .pin_oe(pin_oe),
  .q_bus(q_bus), .ar_hit(ar_hit), .sp_hit(sp_hit), .pld_edge(pld_edge)
);

// File: tb/pld_olmc_bank_tb.sv
module pld_olmc_bank_tb_top;
  import olmc_pkg::*;

  localparam int CLK_P  = 10;
  localparam int N_IN   = 8;
  localparam int N_SL   = 10;
  localparam int NSIG   = N_IN + 1 + N_SL;
  localparam int COLS   = 2 * NSIG;
  localparam int ROWS   = row_base(N_SL, 4, 5, 8, 10) + 2;
  localparam int FUSE_W = ROWS * COLS;
  localparam int CFG_W  = FUSE_W + 2 * N_SL;
  localparam int PCK    = N_IN;

  logic clk = 0;
  logic rst_v = 1, cfg_v = 0, cfg_bit_v = 0, pclk_v = 0;
  logic [N_IN-1:0] in_v = '0;
  logic [N_SL-1:0] pin_in_v = '0;
  logic [N_SL-1:0] pin_out, pin_oe, fb_bus;

  int n_chk = 0, n_err = 0;
  bit img [CFG_W];
  bit act [CFG_W];
  bit mq  [N_SL];
  bit mck;

  always #(CLK_P/2) clk = ~clk;

  pld_olmc_bank dut_i (
    .clk(clk), .rst(rst_v), .cfg_en(cfg_v), .cfg_bit(cfg_bit_v), .in_bus(in_v),
    .pld_clk(pclk_v), .pin_in(pin_in_v), .pin_out(pin_out), .pin_oe(pin_oe), .fb_bus(fb_bus)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int rb(input int s); return row_base(s, 4, 5, 8, 10); endfunction
  function automatic int nt(input int s); return slice_terms(s, 4, 5, 8, 10); endfunction
  function automatic bit m_comb(input int s); return act[FUSE_W+2*s+1]; endfunction
  function automatic bit m_hi(input int s);   return act[FUSE_W+2*s];   endfunction
  function automatic bit fbv(input int s);
    return m_comb(s) ? pin_in_v[s] : mq[s];
  endfunction
  function automatic bit sigv(input int k);
    if (k < N_IN) return in_v[k];
    if (k == PCK) return pclk_v;
    return fbv(k - N_IN - 1);
  endfunction
  function automatic bit term(input int row);
    bit any = 0, all = 1;
    for (int c = 0; c < COLS; c++)
      if (act[row*COLS+c]) begin
        any = 1;
        if ((sigv(c/2) ^ bit'(c % 2)) == 1'b0) all = 0;
      end
    return any & all;
  endfunction
  function automatic bit msum(input int s);
    bit r = 0;
    for (int t = 0; t < nt(s); t++) r |= term(rb(s) + 1 + t);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst_v) begin
      for (int i = 0; i < CFG_W; i++) act[i] = 0;
      for (int s = 0; s < N_SL; s++) mq[s] = 0;
      mck = 0;
    end else begin
      if (!cfg_v) begin
        bit ar, sp, edg;
        bit nxt [N_SL];
        ar  = term(ROWS-2);
        sp  = term(ROWS-1);
        edg = pclk_v & ~mck;
        for (int s = 0; s < N_SL; s++) nxt[s] = sp | msum(s);
        for (int s = 0; s < N_SL; s++)
          if (ar) mq[s] = 0;
          else if (edg) mq[s] = nxt[s];
      end
      mck = pclk_v;
    end
  end

  always @(negedge clk) begin
    if (!rst_v) begin
      if (cfg_v) chk(pin_oe == '0, "R8", 32'(pin_oe), 0);
      else begin
        logic [N_SL-1:0] eo, ee, ef;
        for (int s = 0; s < N_SL; s++) begin
          bit p;
          p = m_comb(s) ? msum(s) : mq[s];
          eo[s] = m_hi(s) ? p : ~p;
          ee[s] = term(rb(s));
          ef[s] = fbv(s);
        end
        chk(pin_out == eo, "R5", 32'(pin_out), 32'(eo));
        chk(pin_oe == ee, "R8", 32'(pin_oe), 32'(ee));
        chk(fb_bus == ef, "R9", 32'(fb_bus), 32'(ef));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(posedge clk); #1; endtask
  task automatic con(input int row, input int k, input bit neg);
    img[row*COLS + 2*k + int'(neg)] = 1;
  endtask
  task automatic mode(input int s, input bit comb, input bit hi);
    img[FUSE_W+2*s] = hi; img[FUSE_W+2*s+1] = comb;
  endtask
  task automatic load_cfg(input bit probe);
    for (int i = 0; i < CFG_W; i++) begin
      cfg_v = 1; cfg_bit_v = img[i];
      if (probe) begin in_v[6] = 1; in_v[5] = 0; pclk_v = i[0]; end
      step();
    end
    cfg_v = 0; cfg_bit_v = 0; pclk_v = 0;
    if (probe) in_v[6] = 0;
    for (int i = 0; i < CFG_W; i++) act[i] = img[i];
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++; n_chk++;
    $display("FAIL R11 watchdog actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < CFG_W; i++) img[i] = 0;
    repeat (3) step();
    rst_v = 0;
    @(negedge clk);
    chk(pin_out == '1, "R10", 32'(pin_out), 32'h3FF);
    chk(pin_oe == '0, "R10", 32'(pin_oe), 0);
    chk(fb_bus == '0, "R10", 32'(fb_bus), 0);
    step();

    // build image: every enable = in7
    for (int s = 0; s < N_SL; s++) con(rb(s), 7, 0);
    mode(0, 1, 1); con(rb(0)+1, 0, 0); con(rb(0)+1, 1, 0);
    mode(1, 1, 0); con(rb(1)+1, 2, 0);
    mode(2, 1, 1); con(rb(2)+1, PCK, 0);
    mode(3, 0, 1); con(rb(3)+1, 5, 0);
    mode(4, 1, 1); con(rb(4)+10, 3, 0); con(rb(4)+10, 4, 1);
    mode(5, 0, 0); con(rb(5)+1, 5, 0);
    mode(6, 1, 1); con(rb(6)+1, N_IN+1+3, 0);
    mode(7, 1, 1); con(rb(7)+1, N_IN+1+0, 0);
    mode(8, 0, 1); mode(9, 0, 1);
    con(ROWS-2, 6, 0); con(ROWS-2, 5, 1);
    con(ROWS-1, 6, 0);
    load_cfg(0);

    in_v[7] = 1; @(negedge clk);
    chk(pin_oe == '1, "R8", 32'(pin_oe), 32'h3FF); step();
    in_v[0] = 1; in_v[1] = 1; @(negedge clk);
    chk(pin_out[0] == 1, "R3", 32'(pin_out[0]), 1); step();
    in_v[1] = 0; @(negedge clk);
    chk(pin_out[0] == 0, "R3", 32'(pin_out[0]), 0); step();
    in_v[2] = 1; @(negedge clk);
    chk(pin_out[1] == 0, "R5", 32'(pin_out[1]), 0); step();
    in_v[2] = 0; @(negedge clk);
    chk(pin_out[1] == 1, "R5", 32'(pin_out[1]), 1); step();
    in_v[3] = 1; in_v[4] = 0; @(negedge clk);
    chk(pin_out[4] == 1, "R1", 32'(pin_out[4]), 1); step();
    in_v[4] = 1; @(negedge clk);
    chk(pin_out[4] == 0, "R1", 32'(pin_out[4]), 0); step();
    pclk_v = 1; @(negedge clk);
    chk(pin_out[2] == 1, "R12", 32'(pin_out[2]), 1); step();
    pclk_v = 0; @(negedge clk);
    chk(pin_out[2] == 0, "R12", 32'(pin_out[2]), 0); step();

    in_v[5] = 1; @(negedge clk);
    chk(fb_bus[3] == 0, "R4", 32'(fb_bus[3]), 0); step();
    @(negedge clk);
    chk(pin_out[3] == 0, "R4", 32'(pin_out[3]), 0); step();
    pclk_v = 1; @(negedge clk);
    chk(pin_out[3] == 0, "R4", 32'(pin_out[3]), 0); step();
    @(negedge clk);
    chk(pin_out[3] == 1, "R4", 32'(pin_out[3]), 1);
    chk(pin_out[5] == 0, "R5", 32'(pin_out[5]), 0);
    chk(pin_out[6] == 1, "R9", 32'(pin_out[6]), 1); step();
    pclk_v = 0; pin_in_v[0] = 1; @(negedge clk);
    chk(pin_out[7] == 1, "R9", 32'(pin_out[7]), 1);
    chk(fb_bus[0] == 1, "R9", 32'(fb_bus[0]), 1); step();
    pin_in_v[0] = 0;

    load_cfg(1);
    @(negedge clk);
    chk(fb_bus[3] == 1, "R11", 32'(fb_bus[3]), 1);
    chk(pin_out[5] == 0, "R11", 32'(pin_out[5]), 0); step();

    in_v[6] = 1; in_v[5] = 0; @(negedge clk);
    chk(fb_bus[3] == 1, "R7", 32'(fb_bus[3]), 1); step();
    @(negedge clk);
    chk(fb_bus[3] == 0, "R7", 32'(fb_bus[3]), 0);
    chk(pin_out[5] == 1, "R7", 32'(pin_out[5]), 1); step();
    in_v[6] = 0;

    in_v[6] = 1; in_v[5] = 1; pclk_v = 1; step();
    in_v[6] = 0; pclk_v = 0; @(negedge clk);
    chk(pin_out[9:8] == 2'b11, "R6", 32'(pin_out[9:8]), 3); step();
    in_v[6] = 1; in_v[5] = 0; pclk_v = 1; step();
    in_v[6] = 0; pclk_v = 0; @(negedge clk);
    chk(pin_out[9:8] == 2'b00, "R7", 32'(pin_out[9:8]), 0); step();
    in_v[6] = 1; in_v[5] = 1; pclk_v = 1; step();
    in_v[6] = 0; pclk_v = 0; @(negedge clk);
    chk(pin_out[9:8] == 2'b11, "R6", 32'(pin_out[9:8]), 3); step();
    pclk_v = 1; step();
    pclk_v = 0; @(negedge clk);
    chk(pin_out[9:8] == 2'b00, "R2", 32'(pin_out[9:8]), 0); step();

    for (int n = 0; n < 400; n++) begin
      in_v = N_IN'($urandom);
      pin_in_v = N_SL'($urandom);
      pclk_v = 1'($urandom);
      step();
    end

    rst_v = 1; step(); step();
    rst_v = 0; @(negedge clk);
    chk(pin_out == '1, "R10", 32'(pin_out), 32'h3FF);
    chk(pin_oe == '0, "R10", 32'(pin_oe), 0);
    step();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule